// File: doc/BRIEF.md
# CPU Event Priority Arbiter

This block sits at the instruction boundary of a processor core and decides which pending event the core services next. It gathers hard requests (reset, machine check), a task-switch trap, the management-mode request and INIT, traps left by the previous instruction, a non-maskable interrupt, maskable interrupts and instruction fetch/decode faults. On every cycle where `boundary` is high it grants at most one of them. It reports the grant as a one-hot `take_evt` pulse together with the vector number the core should dispatch through.

Two local interrupt pins get their role from a small configuration register: maskable, NMI or disabled. The NMI path is edge-triggered and latched. It has its own hardware gate, which a write to a dedicated I/O port address opens or closes, and the interrupt-enable flag does not affect it. A management-mode request raises no vectored interrupt. It sets `smm_active`, and that flag stays set until `rsm_stb` arrives.

All pins are plain control and status signals. No stream data moves through the block, so it has no valid/ready handshake and applies no back-pressure. A grant is a single-cycle pulse that the core must consume in that cycle.

Top module: `evt_prio_arb`

## Requirements
- R1: After reset `take_evt` is all zero, `evt_vec` is 0, `smm_active` is 0, the NMI gate is open and no NMI or SMI is pending.
- R2: At most one `take_evt` bit is set in any cycle. A grant appears in the cycle after a clock edge at which `boundary` was high, and no grant ever follows an edge at which `boundary` was low.
- R3: The bit positions of `take_evt` are: 0 reset, 1 machine check, 2 task-switch trap, 3 SMI, 4 INIT, 5 previous-instruction trap, 6 NMI, 7 maskable interrupt, 8 fetch/decode fault. When several requests are eligible, the lowest bit position wins.
- R4: `evt_vec` is 2 for NMI, 18 for machine check, 1 for the task-switch and previous-instruction traps, `intr_vec` for a maskable interrupt and `fault_vec` for a fault. It is 0 for reset, SMI, INIT and when nothing is granted.
- R5: While `if_flag` is 0, no maskable interrupt is granted. NMI is still granted.
- R6: An I/O write to address 0x70 with data bit 7 set closes the NMI gate, and the same write with bit 7 clear opens it. While the gate is closed no NMI is granted. Writes to any other address leave the gate as it is.
- R7: A rising edge on an NMI-role pin latches one pending NMI. That NMI stays pending while the gate is closed and clears only when it is granted. A pin held high yields exactly one NMI.
- R8: Each local pin has a 2-bit role: 00 or 11 disabled, 01 maskable, 10 NMI. `cfg_roles[1:0]` is pin 0 and `cfg_roles[3:2]` is pin 1, written when `cfg_we` is high. Reset makes pin 0 maskable and pin 1 NMI. A disabled pin is ignored.
- R9: A rising edge on `smi_req` latches a pending SMI. Granting it gives vector 0 and sets `smm_active` in the same cycle as the grant, and `rsm_stb` clears `smm_active` at the next edge.
- R10: While `smm_active` is set, a newly latched SMI is not granted. It is granted at a boundary after the resume.
- R11: While `smm_active` is set, maskable interrupts are still granted when `if_flag` is 1.
- R12: A latched NMI or SMI that loses to a higher-priority event stays pending and is granted at a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Instruction boundary: evaluate and grant this cycle |
| reset_req | input | 1 | Reset event request (level) |
| mcheck_req | input | 1 | Machine-check request (level) |
| task_trap_req | input | 1 | Task-switch trap request (level) |
| smi_req | input | 1 | Management-mode request line (edge-latched) |
| init_req | input | 1 | INIT request (level) |
| prev_trap_req | input | 1 | Trap from the previous instruction (level) |
| fault_req | input | 1 | Fetch/decode fault request (level) |
| fault_vec | input | 8 | Vector of the pending fault |
| lint_pin | input | 2 | Configurable local interrupt pins |
| intr_req | input | 1 | Maskable interrupt request (level) |
| intr_vec | input | 8 | Vector byte supplied with a maskable request |
| if_flag | input | 1 | Interrupt-enable flag |
| io_wr_en | input | 1 | I/O write strobe |
| io_wr_addr | input | 16 | I/O write port address |
| io_wr_data | input | 8 | I/O write data |
| cfg_we | input | 1 | Local pin role register write enable |
| cfg_roles | input | 4 | New pin roles, 2 bits per pin |
| rsm_stb | input | 1 | Resume strobe that leaves management mode |
| take_evt | output | 9 | One-hot event grant pulse |
| evt_vec | output | 8 | Vector of the granted event |
| smm_active | output | 1 | Management mode flag |

## Verification
A grant is registered, so `take_evt` and `evt_vec` become valid one cycle after the edge that sampled `boundary`. The bench raises `boundary` at a falling edge and reads the outputs at the next falling edge, after exactly one rising edge. Edge-latched NMI and SMI need one extra rising edge to become pending. Each stimulus is therefore applied at least one full cycle before the evaluating edge. Gate and role writes take effect at the edge that samples them, and `smm_active` changes at the edge of the SMI grant or the resume, so each is read half a cycle after that edge.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NCLS = 9;

  // grant bit positions, lowest index = highest priority
  localparam int IX_RST  = 0;
  localparam int IX_MCK  = 1;
  localparam int IX_TSW  = 2;
  localparam int IX_SMI  = 3;
  localparam int IX_INIT = 4;
  localparam int IX_DBG  = 5;
  localparam int IX_NMI  = 6;
  localparam int IX_INTR = 7;
  localparam int IX_FLT  = 8;

  localparam logic [7:0] VEC_NMI  = 8'd2;
  localparam logic [7:0] VEC_MCK  = 8'd18;
  localparam logic [7:0] VEC_TRAP = 8'd1;

  typedef enum logic [1:0] {
    ROLE_OFF  = 2'b00,
    ROLE_MASK = 2'b01,
    ROLE_NMI  = 2'b10,
    ROLE_OFFB = 2'b11
  } role_e;
endpackage

// File: rtl/evt_edge_latch.sv
module evt_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic clr,
  output logic pend
);
  logic src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      src_q <= src;
      // a fresh edge wins over a same-cycle clear
      pend  <= (pend & ~clr) | (src & ~src_q);
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !clr |=> pend); // R7
endmodule

// File: rtl/evt_pin_route.sv
module evt_pin_route
  import evt_pkg::*;
#(
  parameter int NPIN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2*NPIN-1:0] cfg_roles,
  input  logic [NPIN-1:0]   pins,
  output logic              mask_any,
  output logic              nmi_any
);
  logic [2*NPIN-1:0] roles;
  logic [NPIN-1:0]   is_mask;
  logic [NPIN-1:0]   is_nmi;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam role_e DEF = (p == 0) ? ROLE_MASK : (p == 1) ? ROLE_NMI : ROLE_OFF;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      roles[2*p +: 2] <= DEF;
      else if (cfg_we) roles[2*p +: 2] <= cfg_roles[2*p +: 2];
    end

    assign is_mask[p] = pins[p] && (roles[2*p +: 2] == ROLE_MASK);
    assign is_nmi[p]  = pins[p] && (roles[2*p +: 2] == ROLE_NMI);
  end

  assign mask_any = |is_mask;
  assign nmi_any  = |is_nmi;

  AST_ROLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(roles)); // R8
endmodule

// File: rtl/evt_prio_sel.sv
module evt_prio_sel #(
  parameter int N = 9
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N-1:0] above;

  for (genvar i = 0; i < N; i++) begin : g_chain
    if (i == 0) begin : g_top
      assign above[i] = 1'b0;
    end else begin : g_rest
      assign above[i] = above[i-1] | req[i-1];
    end
    assign grant[i] = req[i] & ~above[i];
  end
endmodule

// File: rtl/evt_prio_arb.sv
module evt_prio_arb
  import evt_pkg::*;
#(
  parameter int          NPIN      = 2,
  parameter int          VW        = 8,
  parameter int          AW        = 16,
  parameter logic [15:0] GATE_PORT = 16'h0070,
  parameter int          GATE_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic              reset_req,
  input  logic              mcheck_req,
  input  logic              task_trap_req,
  input  logic              smi_req,
  input  logic              init_req,
  input  logic              prev_trap_req,
  input  logic              fault_req,
  input  logic [VW-1:0]     fault_vec,
  input  logic [NPIN-1:0]   lint_pin,
  input  logic              intr_req,
  input  logic [VW-1:0]     intr_vec,
  input  logic              if_flag,
  input  logic              io_wr_en,
  input  logic [AW-1:0]     io_wr_addr,
  input  logic [7:0]        io_wr_data,
  input  logic              cfg_we,
  input  logic [2*NPIN-1:0] cfg_roles,
  input  logic              rsm_stb,
  output logic [NCLS-1:0]   take_evt,
  output logic [VW-1:0]     evt_vec,
  output logic              smm_active
);
  logic            mask_any, nmi_any;
  logic            nmi_pend, smi_pend;
  logic            nmi_blk;
  logic [NCLS-1:0] req, grant, live;
  logic [VW-1:0]   vec_nxt;

  evt_pin_route #(.NPIN(NPIN)) u_route (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_roles(cfg_roles),
    .pins(lint_pin), .mask_any(mask_any), .nmi_any(nmi_any)
  );

  evt_edge_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .src(nmi_any),
    .clr(live[IX_NMI]), .pend(nmi_pend)
  );

  evt_edge_latch u_smi (
    .clk(clk), .rst_n(rst_n), .src(smi_req),
    .clr(live[IX_SMI]), .pend(smi_pend)
  );

  // hardware NMI gate on the dedicated I/O port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      nmi_blk <= 1'b0;
    else if (io_wr_en && io_wr_addr == AW'(GATE_PORT)) nmi_blk <= io_wr_data[GATE_BIT];
  end

  always_comb begin
    req          = '0;
    req[IX_RST]  = reset_req;
    req[IX_MCK]  = mcheck_req;
    req[IX_TSW]  = task_trap_req;
    req[IX_SMI]  = smi_pend & ~smm_active;
    req[IX_INIT] = init_req;
    req[IX_DBG]  = prev_trap_req;
    req[IX_NMI]  = nmi_pend & ~nmi_blk;
    req[IX_INTR] = (intr_req | mask_any) & if_flag;
    req[IX_FLT]  = fault_req;
  end

  evt_prio_sel #(.N(NCLS)) u_sel (.req(req), .grant(grant));

  assign live = boundary ? grant : '0;

  always_comb begin
    vec_nxt = '0;
    if (live[IX_MCK])                  vec_nxt = VW'(VEC_MCK);
    if (live[IX_TSW] || live[IX_DBG])  vec_nxt = VW'(VEC_TRAP);
    if (live[IX_NMI])                  vec_nxt = VW'(VEC_NMI);
    if (live[IX_INTR])                 vec_nxt = intr_vec;
    if (live[IX_FLT])                  vec_nxt = fault_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_evt   <= '0;
      evt_vec    <= '0;
      smm_active <= 1'b0;
    end else begin
      take_evt <= live;
      evt_vec  <= vec_nxt;
      if (live[IX_SMI])  smm_active <= 1'b1;
      else if (rsm_stb)  smm_active <= 1'b0;
    end
  end

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_evt)); // R2
  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> take_evt == '0); // R2
  AST_NMI_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt[IX_NMI] |-> evt_vec == VW'(VEC_NMI)); // R4
  AST_IF_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && !if_flag |=> !take_evt[IX_INTR]); // R5
  AST_GATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_blk |=> !take_evt[IX_NMI]); // R6
  AST_SMM_ON: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt[IX_SMI] |-> smm_active); // R9
  AST_RSM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rsm_stb && smm_active |=> !smm_active); // R9
  AST_SMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    smm_active |=> !take_evt[IX_SMI]); // R10
endmodule

// File: tb/tb_evt_prio_arb.sv
module tb_evt_prio_arb;
  localparam int N = 9;
  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic rst_n, boundary, reset_req, mcheck_req, task_trap_req, smi_req, init_req;
  logic prev_trap_req, fault_req, intr_req, if_flag, io_wr_en, cfg_we, rsm_stb;
  logic [7:0] fault_vec, intr_vec, io_wr_data, evt_vec;
  logic [1:0] lint_pin;
  logic [15:0] io_wr_addr;
  logic [3:0] cfg_roles;
  logic [N-1:0] take_evt;
  logic smm_active;
  int total = 0, bad = 0;

  evt_prio_arb dut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .reset_req(reset_req),
    .mcheck_req(mcheck_req), .task_trap_req(task_trap_req), .smi_req(smi_req),
    .init_req(init_req), .prev_trap_req(prev_trap_req), .fault_req(fault_req),
    .fault_vec(fault_vec), .lint_pin(lint_pin), .intr_req(intr_req),
    .intr_vec(intr_vec), .if_flag(if_flag), .io_wr_en(io_wr_en),
    .io_wr_addr(io_wr_addr), .io_wr_data(io_wr_data), .cfg_we(cfg_we),
    .cfg_roles(cfg_roles), .rsm_stb(rsm_stb), .take_evt(take_evt),
    .evt_vec(evt_vec), .smm_active(smm_active)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // evaluate one boundary; idx<0 means no grant expected
  task automatic eval_expect(input string tag, input int idx, input logic [7:0] vexp);
    @(negedge clk) boundary = 1'b1;
    @(negedge clk) boundary = 1'b0;
    check({tag, " take"}, 32'(take_evt), (idx < 0) ? 32'd0 : 32'(1) << idx);
    check({tag, " vec"}, 32'(evt_vec), (idx < 0) ? 32'd0 : 32'(vexp));
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk) begin io_wr_en = 1'b1; io_wr_addr = a; io_wr_data = d; end
    @(negedge clk) io_wr_en = 1'b0;
  endtask

  task automatic resume();
    @(negedge clk) rsm_stb = 1'b1;
    @(negedge clk) rsm_stb = 1'b0;
  endtask

  task automatic pulse_nmi_pin(input int p);
    @(negedge clk) lint_pin[p] = 1'b1;
    @(negedge clk) lint_pin[p] = 1'b0;
  endtask

  task automatic pulse_smi();
    @(negedge clk) smi_req = 1'b1;
    @(negedge clk) smi_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 take after reset", 32'(take_evt), 0);
    check("R1 vec after reset", 32'(evt_vec), 0);
    check("R1 smm after reset", 32'(smm_active), 0);
    eval_expect("R1 nothing pending", -1, 0);
    // R8 default roles
    @(negedge clk) begin lint_pin[0] = 1'b1; intr_vec = 8'h41; end
    eval_expect("R8 pin0 maskable", 7, 8'h41);
    @(negedge clk) lint_pin[0] = 1'b0;
    pulse_nmi_pin(1);
    eval_expect("R8 pin1 nmi", 6, 2);
  endtask

  task automatic t_no_boundary();
    @(negedge clk) intr_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2 no grant without boundary", 32'(take_evt), 0);
    end
    eval_expect("R2 grant on boundary", 7, 8'h41);
    @(negedge clk) intr_req = 1'b0;
  endtask

  task automatic t_priority();
    @(negedge clk) begin
      reset_req = 1; mcheck_req = 1; task_trap_req = 1; init_req = 1;
      prev_trap_req = 1; intr_req = 1; fault_req = 1;
      intr_vec = 8'h33; fault_vec = 8'h0e;
    end
    pulse_smi();
    pulse_nmi_pin(1);
    eval_expect("R3 reset first", 0, 0);
    reset_req = 0;
    eval_expect("R3 R4 machine check", 1, 18);
    mcheck_req = 0;
    eval_expect("R3 task switch trap", 2, 1);
    task_trap_req = 0;
    eval_expect("R12 R9 smi after higher", 3, 0);
    check("R9 smm set", 32'(smm_active), 1);
    eval_expect("R3 init", 4, 0);
    init_req = 0;
    eval_expect("R3 prev trap", 5, 1);
    prev_trap_req = 0;
    eval_expect("R12 nmi kept pending", 6, 2);
    eval_expect("R11 maskable in smm", 7, 8'h33);
    intr_req = 0;
    eval_expect("R3 R4 fault last", 8, 8'h0e);
    fault_req = 0;
    resume();
    check("R9 smm cleared", 32'(smm_active), 0);
  endtask

  task automatic t_ifmask();
    @(negedge clk) begin if_flag = 0; intr_req = 1; intr_vec = 8'h50; end
    pulse_nmi_pin(1);
    eval_expect("R5 nmi despite if=0", 6, 2);
    eval_expect("R5 maskable blocked", -1, 0);
    @(negedge clk) if_flag = 1;
    eval_expect("R5 maskable after enable", 7, 8'h50);
    @(negedge clk) intr_req = 0;
  endtask

  task automatic t_gate();
    io_write(16'h0070, 8'h80);
    pulse_nmi_pin(1);
    eval_expect("R6 gate closed", -1, 0);
    io_write(16'h0071, 8'h00);
    eval_expect("R6 other port ignored", -1, 0);
    io_write(16'h0070, 8'h00);
    eval_expect("R7 held nmi after open", 6, 2);
    eval_expect("R7 nmi cleared", -1, 0);
  endtask

  task automatic t_level_nmi();
    @(negedge clk) lint_pin[1] = 1'b1;
    repeat (3) @(negedge clk);
    eval_expect("R7 level nmi once", 6, 2);
    eval_expect("R7 level no repeat", -1, 0);
    @(negedge clk) lint_pin[1] = 1'b0;
  endtask

  task automatic t_smi_nest();
    pulse_smi();
    eval_expect("R9 smi vec 0", 3, 0);
    check("R9 smm on", 32'(smm_active), 1);
    pulse_smi();
    eval_expect("R10 smi held in smm", -1, 0);
    check("R10 smm still on", 32'(smm_active), 1);
    resume();
    check("R9 resume clears", 32'(smm_active), 0);
    eval_expect("R10 smi after resume", 3, 0);
    resume();
  endtask

  task automatic t_cfg();
    @(negedge clk) begin cfg_we = 1; cfg_roles = 4'b0010; end
    @(negedge clk) cfg_we = 0;
    @(negedge clk) lint_pin[1] = 1'b1;
    eval_expect("R8 disabled pin ignored", -1, 0);
    @(negedge clk) lint_pin[1] = 1'b0;
    pulse_nmi_pin(0);
    eval_expect("R8 pin0 as nmi", 6, 2);
    @(negedge clk) begin cfg_we = 1; cfg_roles = 4'b1001; end
    @(negedge clk) cfg_we = 0;
  endtask

  initial begin
    rst_n = 0; boundary = 0; reset_req = 0; mcheck_req = 0; task_trap_req = 0;
    smi_req = 0; init_req = 0; prev_trap_req = 0; fault_req = 0; intr_req = 0;
    if_flag = 1; io_wr_en = 0; cfg_we = 0; rsm_stb = 0; fault_vec = 0;
    intr_vec = 0; io_wr_data = 0; lint_pin = 0; io_wr_addr = 0; cfg_roles = 4'b1001;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_no_boundary();
    t_priority();
    t_ifmask();
    t_gate();
    t_level_nmi();
    t_smi_nest();
    t_cfg();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule